// File: doc/BRIEF.md
# USB Endpoint Interrupt Aggregator

This block gathers the interrupt causes of a USB device controller into one 32-bit status word and drives a single interrupt line. Ten endpoint-direction bits (the control endpoint in both directions, then four further endpoints in both directions) are set by transfer-complete, skip-complete, SETUP-received and, when permitted by a per-class control, NAK-sent strobes. One more bit is set by a once-per-millisecond tick while the device is connected and VBUS is present. Another bit is set by a device-status event.

Software uses three write targets, chosen by a 2-bit selector. Target 0 clears status bits by writing 1. Target 1 sets status bits by writing 1. Target 2 loads the enable mask. A combinational read port returns the status word (on selector 0 or 1), the enable mask (on selector 2) or zero (on selector 3). The interrupt line is high whenever any status bit and its enable bit are both 1.

Top module: `usb_ep_irq_agg`

## Requirements
- R1: After reset the status word and the enable mask are zero and `irqOut` is low.
- R2: A pulse on `epDoneStb[i]` sets status bit i on the next clock edge. The bit map is: bit 0 control OUT, bit 1 control IN, bit 2k endpoint k OUT, and bit 2k+1 endpoint k IN, for k = 1 to 4.
- R3: A pulse on `epSkipStb[i]`, which signals that a software skip has finished, sets status bit i.
- R4: A pulse on `setupStb` sets status bit 0.
- R5: A pulse on `epNakStb[i]` sets bit i only while the NAK control for that bit's class is 1. The classes are: `nakIrqCtrlOut` for bit 0, `nakIrqCtrlIn` for bit 1, `nakIrqBulkOut` for even bits 2 to 8, and `nakIrqBulkIn` for odd bits 3 to 9.
- R6: A pulse on `msTick` sets bit 30 only when `connectOn` and `vbusOk` are both 1.
- R7: A pulse on `devEventStb` sets bit 31.
- R8: A write with selector 0 clears every status bit written as 1. Bits written as 0 keep their value.
- R9: A write with selector 1 sets every status bit written as 1. A read with selector 1 returns the status word.
- R10: A write with selector 2 loads the enable mask, and a read with selector 2 returns it. `irqOut` is the OR, over all bits, of each status bit ANDed with its enable bit. A read with selector 3 returns zero.
- R11: When a hardware event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R12: Bits 10 to 29 of the status word and of the enable mask always read as 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| epDoneStb | input | 10 | Per-bit transfer-complete strobes |
| epSkipStb | input | 10 | Per-bit skip-complete strobes |
| epNakStb | input | 10 | Per-bit NAK-sent strobes |
| setupStb | input | 1 | SETUP received on control OUT |
| nakIrqCtrlOut | input | 1 | NAK counts for control OUT |
| nakIrqCtrlIn | input | 1 | NAK counts for control IN |
| nakIrqBulkOut | input | 1 | NAK counts for bulk/interrupt OUT |
| nakIrqBulkIn | input | 1 | NAK counts for bulk/interrupt IN |
| msTick | input | 1 | Millisecond tick |
| connectOn | input | 1 | Connect requested by software |
| vbusOk | input | 1 | Debounced VBUS present |
| devEventStb | input | 1 | Device status change event |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 clear, 1 set, 2 enable |
| wrData | input | 32 | Write data |
| rdSel | input | 2 | Read selector |
| rdData | output | 32 | Read data |
| irqOut | output | 1 | Interrupt line |

## Verification
The collision that matters is a hardware event and a software write-1-to-clear landing on the same status bit in the same cycle. The bench provokes it by raising a done strobe in the very cycle that clears that bit, with a neighbouring bit cleared at the same time as a control. It then reads the status word after that edge, and the targeted bit must still be 1 while the neighbour must be 0. The interrupt line is judged in the same read.

// File: rtl/usb_ep_irq_pkg.sv
package usb_ep_irq_pkg;

  localparam int REG_W     = 32;
  localparam int FRAME_BIT = 30;
  localparam int DEV_BIT   = 31;

  typedef enum logic [1:0] {
    SEL_CLEAR  = 2'd0,
    SEL_SET    = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [REG_W-1:0] hwSet;
    logic [REG_W-1:0] swClr;
    logic [REG_W-1:0] swSet;
    logic             enWr;
    logic [REG_W-1:0] enData;
  } irqCtl_t;

  function automatic logic [REG_W-1:0] validMask(input int epBits);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < epBits; i++) m[i] = 1'b1;
    m[FRAME_BIT] = 1'b1;
    m[DEV_BIT]   = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/usb_ep_irq_ctrl.sv
module usb_ep_irq_ctrl
  import usb_ep_irq_pkg::*;
#(
  parameter int NUM_EP = 5,
  localparam int EP_BITS = 2 * NUM_EP
) (
  input  logic [EP_BITS-1:0] epDoneStb,
  input  logic [EP_BITS-1:0] epSkipStb,
  input  logic [EP_BITS-1:0] epNakStb,
  input  logic               setupStb,
  input  logic               nakIrqCtrlOut,
  input  logic               nakIrqCtrlIn,
  input  logic               nakIrqBulkOut,
  input  logic               nakIrqBulkIn,
  input  logic               msTick,
  input  logic               connectOn,
  input  logic               vbusOk,
  input  logic               devEventStb,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [REG_W-1:0]   wrData,
  output irqCtl_t            ctl
);

  localparam logic [REG_W-1:0] VALID = validMask(EP_BITS);

  logic [EP_BITS-1:0] nakGate;
  logic [EP_BITS-1:0] epSet;
  regSel_e            selDec;

  // Each endpoint bit picks the NAK control of its class
  for (genvar i = 0; i < EP_BITS; i++) begin : g_nakGate
    if (i == 0) begin : g_ctrlOut
      assign nakGate[i] = nakIrqCtrlOut;
    end else if (i == 1) begin : g_ctrlIn
      assign nakGate[i] = nakIrqCtrlIn;
    end else if ((i % 2) == 0) begin : g_bulkOut
      assign nakGate[i] = nakIrqBulkOut;
    end else begin : g_bulkIn
      assign nakGate[i] = nakIrqBulkIn;
    end
  end

  assign selDec = regSel_e'(wrSel);

  always_comb begin
    epSet    = epDoneStb | epSkipStb | (epNakStb & nakGate);
    epSet[0] = epSet[0] | setupStb;
  end

  always_comb begin
    ctl = '0;
    ctl.hwSet[EP_BITS-1:0] = epSet;
    ctl.hwSet[FRAME_BIT]   = msTick & connectOn & vbusOk;
    ctl.hwSet[DEV_BIT]     = devEventStb;
    if (wrEn) begin
      unique case (selDec)
        SEL_CLEAR:  ctl.swClr = wrData & VALID;
        SEL_SET:    ctl.swSet = wrData & VALID;
        SEL_ENABLE: begin
          ctl.enWr   = 1'b1;
          ctl.enData = wrData & VALID;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/usb_ep_irq_dp.sv
module usb_ep_irq_dp
  import usb_ep_irq_pkg::*;
#(
  parameter int NUM_EP = 5,
  localparam int EP_BITS = 2 * NUM_EP
) (
  input  logic             clk,
  input  logic             rstN,
  input  irqCtl_t          ctl,
  input  logic [1:0]       rdSel,
  output logic [REG_W-1:0] statusQ,
  output logic [REG_W-1:0] enableQ,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut
);

  localparam logic [REG_W-1:0] VALID = validMask(EP_BITS);

  logic [REG_W-1:0] statusNext;

  // Sets are ORed in after the clear, so an event beats a clear
  assign statusNext = ((statusQ & ~ctl.swClr) | ctl.swSet | ctl.hwSet) & VALID;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= statusNext;
      if (ctl.enWr) enableQ <= ctl.enData;
    end
  end

  always_comb begin
    unique case (regSel_e'(rdSel))
      SEL_CLEAR, SEL_SET: rdData = statusQ;
      SEL_ENABLE:         rdData = enableQ;
      default:            rdData = '0;
    endcase
  end

  assign irqOut = |(statusQ & enableQ);

endmodule

// File: rtl/usb_ep_irq_agg.sv
module usb_ep_irq_agg
  import usb_ep_irq_pkg::*;
#(
  parameter int NUM_EP = 5,
  localparam int EP_BITS = 2 * NUM_EP
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [EP_BITS-1:0] epDoneStb,
  input  logic [EP_BITS-1:0] epSkipStb,
  input  logic [EP_BITS-1:0] epNakStb,
  input  logic               setupStb,
  input  logic               nakIrqCtrlOut,
  input  logic               nakIrqCtrlIn,
  input  logic               nakIrqBulkOut,
  input  logic               nakIrqBulkIn,
  input  logic               msTick,
  input  logic               connectOn,
  input  logic               vbusOk,
  input  logic               devEventStb,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [31:0]        wrData,
  input  logic [1:0]         rdSel,
  output logic [31:0]        rdData,
  output logic               irqOut
);

  irqCtl_t          ctl;
  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] enableQ;

  usb_ep_irq_ctrl #(.NUM_EP(NUM_EP)) u_ctrl (
    .epDoneStb     (epDoneStb),
    .epSkipStb     (epSkipStb),
    .epNakStb      (epNakStb),
    .setupStb      (setupStb),
    .nakIrqCtrlOut (nakIrqCtrlOut),
    .nakIrqCtrlIn  (nakIrqCtrlIn),
    .nakIrqBulkOut (nakIrqBulkOut),
    .nakIrqBulkIn  (nakIrqBulkIn),
    .msTick        (msTick),
    .connectOn     (connectOn),
    .vbusOk        (vbusOk),
    .devEventStb   (devEventStb),
    .wrEn          (wrEn),
    .wrSel         (wrSel),
    .wrData        (wrData),
    .ctl           (ctl)
  );

  usb_ep_irq_dp #(.NUM_EP(NUM_EP)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .rdSel   (rdSel),
    .statusQ (statusQ),
    .enableQ (enableQ),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/usb_ep_irq_agg_chk.sv
module usb_ep_irq_agg_chk #(
  parameter int NUM_EP = 5,
  localparam int EP_BITS = 2 * NUM_EP
) (
  input logic               clk,
  input logic               rstN,
  input logic [EP_BITS-1:0] epDoneStb,
  input logic               setupStb,
  input logic               msTick,
  input logic               connectOn,
  input logic               vbusOk,
  input logic               wrEn,
  input logic [1:0]         wrSel,
  input logic [31:0]        statusQ,
  input logic [31:0]        enableQ,
  input logic               irqOut
);

  // R2 and R11: a done strobe sets its bit even during a clear write
  a_r2_done_sets: assert property (@(posedge clk) disable iff (!rstN)
    (epDoneStb != '0) |=> ((statusQ[EP_BITS-1:0] & $past(epDoneStb)) == $past(epDoneStb)));

  a_r4_setup_sets: assert property (@(posedge clk) disable iff (!rstN)
    setupStb |=> statusQ[0]);

  a_r6_frame_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[30]) |-> ($past(msTick && connectOn && vbusOk) || ($past(wrEn) && $past(wrSel) == 2'd1)));

  a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    ((~statusQ & $past(statusQ)) != '0) |-> ($past(wrEn) && $past(wrSel) == 2'd0));

  a_r12_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[29:EP_BITS] == '0) && (enableQ[29:EP_BITS] == '0));

  a_r10_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0) |-> !irqOut);

endmodule

bind usb_ep_irq_agg usb_ep_irq_agg_chk #(.NUM_EP(NUM_EP)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .epDoneStb (epDoneStb),
  .setupStb  (setupStb),
  .msTick    (msTick),
  .connectOn (connectOn),
  .vbusOk    (vbusOk),
  .wrEn      (wrEn),
  .wrSel     (wrSel),
  .statusQ   (statusQ),
  .enableQ   (enableQ),
  .irqOut    (irqOut)
);

// File: tb/test_usb_ep_irq_agg.sv
module test_usb_ep_irq_agg;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  epDoneStb = '0, epSkipStb = '0, epNakStb = '0;
  logic        setupStb = 1'b0;
  logic        nakIrqCtrlOut = 1'b0, nakIrqCtrlIn = 1'b0;
  logic        nakIrqBulkOut = 1'b0, nakIrqBulkIn = 1'b0;
  logic        msTick = 1'b0, connectOn = 1'b0, vbusOk = 1'b0;
  logic        devEventStb = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdSel = '0;
  logic [31:0] rdData;
  logic        irqOut;

  typedef struct {
    logic [1:0]  sel;
    logic [31:0] val;
    logic        irq;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_irq_agg i_usb_ep_irq_agg (
    .clk(clk), .rstN(rstN), .epDoneStb(epDoneStb), .epSkipStb(epSkipStb),
    .epNakStb(epNakStb), .setupStb(setupStb), .nakIrqCtrlOut(nakIrqCtrlOut),
    .nakIrqCtrlIn(nakIrqCtrlIn), .nakIrqBulkOut(nakIrqBulkOut),
    .nakIrqBulkIn(nakIrqBulkIn), .msTick(msTick), .connectOn(connectOn),
    .vbusOk(vbusOk), .devEventStb(devEventStb), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .irqOut(irqOut)
  );

  // Monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        compared++;
        if (rdData !== it.val || irqOut !== it.irq) begin
          mismatched++;
          $display("FAIL %s: rdData=%h irq=%b expected rdData=%h irq=%b",
                   it.tag, rdData, irqOut, it.val, it.irq);
        end
      end
    end
  end

  task automatic startCycle();
    @(negedge clk);
  endtask

  task automatic endCycle();
    @(posedge clk);
    #1;
    epDoneStb = '0; epSkipStb = '0; epNakStb = '0;
    setupStb = 1'b0; msTick = 1'b0; devEventStb = 1'b0; wrEn = 1'b0;
  endtask

  task automatic expectRead(input logic [1:0] sel, input logic [31:0] val,
                            input logic irq, input string tag);
    expItem_t it;
    rdSel  = sel;
    it.sel = sel; it.val = val; it.irq = irq; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] data);
    startCycle();
    wrEn = 1'b1; wrSel = sel; wrData = data;
    endCycle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    expectRead(2'd0, 32'h0, 1'b0, "R1 status after reset");
    expectRead(2'd2, 32'h0, 1'b0, "R1 enable after reset");

    // R2: done strobes on EP1 OUT (bit 2) and EP4 IN (bit 9)
    startCycle(); epDoneStb = 10'h204; endCycle();
    expectRead(2'd0, 32'h204, 1'b0, "R2 done sets bits 2 and 9");

    // R8: partial clear, zero write, full clear
    regWrite(2'd0, 32'h4);
    expectRead(2'd0, 32'h200, 1'b0, "R8 clear bit 2 only");
    regWrite(2'd0, 32'h0);
    expectRead(2'd0, 32'h200, 1'b0, "R8 writing zero keeps bits");
    regWrite(2'd0, 32'h200);
    expectRead(2'd0, 32'h0, 1'b0, "R8 clear bit 9");

    // R3: skip completion on control IN
    startCycle(); epSkipStb = 10'h002; endCycle();
    expectRead(2'd0, 32'h2, 1'b0, "R3 skip sets bit 1");
    regWrite(2'd0, 32'hFFFF_FFFF);

    // R4: SETUP sets bit 0
    startCycle(); setupStb = 1'b1; endCycle();
    expectRead(2'd0, 32'h1, 1'b0, "R4 setup sets bit 0");
    regWrite(2'd0, 32'h1);

    // R5: NAK gating by class
    startCycle(); epNakStb = 10'h3FF; endCycle();
    expectRead(2'd0, 32'h0, 1'b0, "R5 NAK ignored with all controls off");
    nakIrqCtrlOut = 1'b1;
    startCycle(); epNakStb = 10'h3FF; endCycle();
    expectRead(2'd0, 32'h1, 1'b0, "R5 control OUT NAK class");
    regWrite(2'd0, 32'h3FF);
    nakIrqCtrlOut = 1'b0; nakIrqBulkIn = 1'b1;
    startCycle(); epNakStb = 10'h3FF; endCycle();
    expectRead(2'd0, 32'h2A8, 1'b0, "R5 bulk IN NAK class");
    regWrite(2'd0, 32'h3FF);
    nakIrqBulkIn = 1'b0; nakIrqBulkOut = 1'b1; nakIrqCtrlIn = 1'b1;
    startCycle(); epNakStb = 10'h3FF; endCycle();
    expectRead(2'd0, 32'h156, 1'b0, "R5 bulk OUT and control IN NAK classes");
    regWrite(2'd0, 32'h3FF);
    nakIrqBulkOut = 1'b0; nakIrqCtrlIn = 1'b0;

    // R6: frame tick gated by connect and VBUS
    connectOn = 1'b1; vbusOk = 1'b0;
    startCycle(); msTick = 1'b1; endCycle();
    expectRead(2'd0, 32'h0, 1'b0, "R6 tick ignored without VBUS");
    vbusOk = 1'b1;
    startCycle(); msTick = 1'b1; endCycle();
    expectRead(2'd0, 32'h4000_0000, 1'b0, "R6 tick sets bit 30");
    regWrite(2'd0, 32'h4000_0000);

    // R7: device event
    startCycle(); devEventStb = 1'b1; endCycle();
    expectRead(2'd0, 32'h8000_0000, 1'b0, "R7 device event sets bit 31");

    // R9: set alias and its readback
    regWrite(2'd1, 32'h3);
    expectRead(2'd1, 32'h8000_0003, 1'b0, "R9 alias sets bits, reads status");

    // R12: unused positions cannot be set
    regWrite(2'd1, 32'hFFFF_FFFF);
    expectRead(2'd0, 32'hC000_03FF, 1'b0, "R12 unused status bits stay 0");
    regWrite(2'd0, 32'hFFFF_FFFF);
    expectRead(2'd0, 32'h0, 1'b0, "R8 clear all");

    // R10: enable mask and interrupt line
    regWrite(2'd2, 32'hFFFF_FFFF);
    expectRead(2'd2, 32'hC000_03FF, 1'b0, "R10 R12 enable readback masked");
    regWrite(2'd1, 32'h20);
    expectRead(2'd0, 32'h20, 1'b1, "R10 irq with enabled bit");
    regWrite(2'd2, 32'hFFFF_FFDF);
    expectRead(2'd0, 32'h20, 1'b0, "R10 irq low when bit disabled");
    expectRead(2'd3, 32'h0, 1'b0, "R10 selector 3 reads zero");
    regWrite(2'd2, 32'hFFFF_FFFF);

    // R11: event and clear on the same bit in the same cycle
    regWrite(2'd1, 32'h10);
    startCycle();
    epDoneStb = 10'h010; wrEn = 1'b1; wrSel = 2'd0; wrData = 32'h30;
    endCycle();
    expectRead(2'd0, 32'h10, 1'b1, "R11 set wins over clear");

    finished = 1'b1;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule